// File: doc/BRIEF.md
# Chained Read Handoff Buffer

This block sits between a memory-fetch engine and a channel interface. A select-read command announces a byte count. The fetch engine then streams that many bytes into a local store. The block keeps those bytes for exactly one follow-on command. When that command is a chained read, the block streams out the smaller of the two counts toward the channel. It flags a length mismatch unless suppression is requested, and then reports end-of-channel and end-of-device as two separate one-cycle pulses.

Whatever the follow-on read does not consume is dropped. A command that is not a chained read also drops the data. A unit-check abort invalidates everything at once.

Both byte streams use valid/ready. The fill side moves a byte on each clock edge where `fill_valid` and `fill_ready` are both high. `fill_ready` is high only while the store still expects bytes. The delivery side moves a byte on each edge where `out_valid` and `out_ready` are both high. Once `out_valid` is raised, it stays high with `out_data` unchanged until the byte is taken, so the channel side may stall for any number of cycles. Control and status pins are plain levels or pulses.

Top module: `rd_handoff_buf`

## Requirements
- R1: A `sel_start` pulse, seen while the block is idle or holding data, produces a `ch_end` pulse in the following cycle. `fill_ready` is then high until `sel_count` bytes have been stored.
- R2: `dev_end` pulses in the cycle after the last stored byte's handshake; for a count of zero, it pulses in the cycle after the select `ch_end`. No fill byte and no output byte is ever offered in the same cycle.
- R3: A command with `cmd_chain`=1 and `cmd_opcode` equal to parameter READ_OP (default 8'h02) delivers min(`cmd_count`, stored count) bytes on `out_data`, in the order they were stored, starting from the first.
- R4: From the cycle after a chained read is accepted, `bad_len` is 1 exactly when its count differs from the stored count and `cmd_sli` is 0. When no data is held, the stored count is taken as zero. `bad_len` clears on the next select, the next command, or a unit check.
- R5: After a chained read's last byte, `ch_end` pulses. `dev_end` pulses in the very next cycle.
- R6: Bytes left over after a chained read are discarded. A second chained read gets zero bytes, still pulses `ch_end` then `dev_end`, and raises `bad_len` if its count is nonzero and `cmd_sli` is 0.
- R7: While data is held, a command that is not chained, or has another opcode, discards the data. That command gives no `ch_end`, `dev_end` or `out_valid`.
- R8: `unit_check` aborts any activity in the next cycle. `out_valid`, `fill_ready`, `ch_end` and `dev_end` all go low, and the stored data is invalidated.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays stable.
- R10: `ch_end` and `dev_end` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_start | input | 1 | Select-read accepted (one-cycle pulse) |
| sel_count | input | CW | Bytes the select will store (at most DEPTH) |
| fill_valid | input | 1 | Fill byte present |
| fill_data | input | 8 | Fill byte |
| fill_ready | output | 1 | Store accepts a fill byte |
| cmd_valid | input | 1 | Next command presented (one-cycle pulse) |
| cmd_opcode | input | 8 | Next command opcode |
| cmd_chain | input | 1 | Next command arrived via command chaining |
| cmd_count | input | CW | Next command byte count |
| cmd_sli | input | 1 | Suppress length mismatch indication |
| unit_check | input | 1 | Abort: breaks chaining, invalidates the store |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Output byte |
| out_ready | input | 1 | Channel side takes the byte |
| ch_end | output | 1 | Channel-end pulse |
| dev_end | output | 1 | Device-end pulse |
| bad_len | output | 1 | Length mismatch of the last chained read |

## Verification
The properties assume that `sel_start` and `cmd_valid` are single-cycle pulses, offered only when no fill or delivery is in progress, and that `sel_count` never exceeds DEPTH. The bench keeps to this by waiting for each select's `dev_end`, and for each read's `dev_end`, before presenting the next pulse. The one deliberate exception is `unit_check`, which is asserted in the middle of a fill to exercise the abort path. Back-pressure is applied by an irregular `out_ready` pattern during a full-depth transfer.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [2:0] {
    HB_IDLE = 3'd0,
    HB_FILL = 3'd1,
    HB_HOLD = 3'd2,
    HB_SEND = 3'd3,
    HB_DEND = 3'd4
  } hb_state_e;
endpackage

// File: rtl/hb_store.sv
module hb_store #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/hb_lencmp.sv
module hb_lencmp #(
  parameter int CW = 12
) (
  input  logic [CW-1:0] req_count,
  input  logic [CW-1:0] held_count,
  input  logic          held,
  input  logic          sli,
  output logic [CW-1:0] xfer_count,
  output logic          mismatch
);
  logic [CW-1:0] avail;

  always_comb begin
    avail      = held ? held_count : '0;
    xfer_count = (req_count < avail) ? req_count : avail;
    mismatch   = (req_count != avail) && !sli;
  end
endmodule

// File: rtl/hb_seq.sv
module hb_seq
  import hb_pkg::*;
#(
  parameter int          CW      = 12,
  parameter logic [7:0]  READ_OP = 8'h02
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_start,
  input  logic [CW-1:0] sel_count,
  input  logic          fill_valid,
  input  logic          cmd_valid,
  input  logic [7:0]    cmd_opcode,
  input  logic          cmd_chain,
  input  logic          unit_check,
  input  logic          out_ready,
  input  logic [CW-1:0] xfer_in,
  input  logic          mismatch_in,
  output logic          held,
  output logic [CW-1:0] held_count,
  output logic          wr_en,
  output logic [CW-1:0] wr_ptr,
  output logic [CW-1:0] rd_ptr,
  output logic          fill_ready,
  output logic          out_valid,
  output logic          ch_end,
  output logic          dev_end,
  output logic          bad_len,
  output logic          busy,
  output logic          in_dend
);
  hb_state_e st_q;
  logic [CW-1:0] cnt_q, wr_q, rd_q, xfer_q;
  logic ce_q, de_q, bad_q;
  logic is_read, out_fire, fill_done, send_done;

  assign is_read    = cmd_chain && (cmd_opcode == READ_OP);
  assign fill_ready = (st_q == HB_FILL) && (wr_q != cnt_q);
  assign out_valid  = (st_q == HB_SEND) && (rd_q != xfer_q);
  assign wr_en      = fill_ready && fill_valid;
  assign out_fire   = out_valid && out_ready;
  assign fill_done  = (wr_q == cnt_q) || (wr_en && (wr_q + CW'(1) == cnt_q));
  assign send_done  = (rd_q == xfer_q) || (out_fire && (rd_q + CW'(1) == xfer_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= HB_IDLE;
      cnt_q  <= '0;
      wr_q   <= '0;
      rd_q   <= '0;
      xfer_q <= '0;
      ce_q   <= 1'b0;
      de_q   <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      ce_q <= 1'b0;
      de_q <= 1'b0;
      if (unit_check) begin
        st_q  <= HB_IDLE;
        bad_q <= 1'b0;
      end else begin
        unique case (st_q)
          HB_IDLE, HB_HOLD: begin
            if (sel_start) begin
              cnt_q <= sel_count;
              wr_q  <= '0;
              ce_q  <= 1'b1;
              bad_q <= 1'b0;
              st_q  <= HB_FILL;
            end else if (cmd_valid) begin
              if (is_read) begin
                xfer_q <= xfer_in;
                bad_q  <= mismatch_in;
                rd_q   <= '0;
                st_q   <= HB_SEND;
              end else begin
                bad_q <= 1'b0;
                st_q  <= HB_IDLE;
              end
            end
          end
          HB_FILL: begin
            if (wr_en) wr_q <= wr_q + CW'(1);
            if (fill_done) begin
              de_q <= 1'b1;
              st_q <= HB_HOLD;
            end
          end
          HB_SEND: begin
            if (out_fire) rd_q <= rd_q + CW'(1);
            if (send_done) begin
              ce_q <= 1'b1;
              st_q <= HB_DEND;
            end
          end
          HB_DEND: begin
            de_q <= 1'b1;
            st_q <= HB_IDLE;
          end
          default: st_q <= HB_IDLE;
        endcase
      end
    end
  end

  assign held       = (st_q == HB_HOLD);
  assign held_count = cnt_q;
  assign wr_ptr     = wr_q;
  assign rd_ptr     = rd_q;
  assign ch_end     = ce_q;
  assign dev_end    = de_q;
  assign bad_len    = bad_q;
  assign busy       = (st_q == HB_FILL) || (st_q == HB_SEND) || (st_q == HB_DEND);
  assign in_dend    = (st_q == HB_DEND);
endmodule

// File: rtl/rd_handoff_buf.sv
module rd_handoff_buf #(
  parameter int         DEPTH   = 2048,
  parameter logic [7:0] READ_OP = 8'h02,
  localparam int        AW      = $clog2(DEPTH),
  localparam int        CW      = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_start,
  input  logic [CW-1:0] sel_count,
  input  logic          fill_valid,
  input  logic [7:0]    fill_data,
  output logic          fill_ready,
  input  logic          cmd_valid,
  input  logic [7:0]    cmd_opcode,
  input  logic          cmd_chain,
  input  logic [CW-1:0] cmd_count,
  input  logic          cmd_sli,
  input  logic          unit_check,
  output logic          out_valid,
  output logic [7:0]    out_data,
  input  logic          out_ready,
  output logic          ch_end,
  output logic          dev_end,
  output logic          bad_len
);
  logic          held, wr_en, mismatch, busy, in_dend;
  logic [CW-1:0] held_count, xfer_count, wr_ptr, rd_ptr;

  hb_lencmp #(.CW(CW)) cmp_i (
    .req_count (cmd_count),
    .held_count(held_count),
    .held      (held),
    .sli       (cmd_sli),
    .xfer_count(xfer_count),
    .mismatch  (mismatch)
  );

  hb_seq #(.CW(CW), .READ_OP(READ_OP)) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_start  (sel_start),
    .sel_count  (sel_count),
    .fill_valid (fill_valid),
    .cmd_valid  (cmd_valid),
    .cmd_opcode (cmd_opcode),
    .cmd_chain  (cmd_chain),
    .unit_check (unit_check),
    .out_ready  (out_ready),
    .xfer_in    (xfer_count),
    .mismatch_in(mismatch),
    .held       (held),
    .held_count (held_count),
    .wr_en      (wr_en),
    .wr_ptr     (wr_ptr),
    .rd_ptr     (rd_ptr),
    .fill_ready (fill_ready),
    .out_valid  (out_valid),
    .ch_end     (ch_end),
    .dev_end    (dev_end),
    .bad_len    (bad_len),
    .busy       (busy),
    .in_dend    (in_dend)
  );

  hb_store #(.DEPTH(DEPTH)) store_i (
    .clk  (clk),
    .we   (wr_en),
    .waddr(wr_ptr[AW-1:0]),
    .wdata(fill_data),
    .raddr(rd_ptr[AW-1:0]),
    .rdata(out_data)
  );
endmodule

// File: rtl/hb_chk.sv
module hb_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel_start,
  input logic       unit_check,
  input logic       busy,
  input logic       in_dend,
  input logic       fill_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       ch_end,
  input logic       dev_end
);
  // R10
  excl_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ch_end && dev_end));

  // R1
  sel_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_start && !busy && !unit_check) |=> ch_end);

  // R8
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unit_check |=> (!out_valid && !fill_ready && !ch_end && !dev_end));

  // R5
  read_de_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_end && in_dend && !unit_check) |=> dev_end);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !unit_check) |=> (out_valid && $stable(out_data)));

  // R2
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_ready && out_valid));
endmodule

bind rd_handoff_buf hb_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .sel_start (sel_start),
  .unit_check(unit_check),
  .busy      (busy),
  .in_dend   (in_dend),
  .fill_ready(fill_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .ch_end    (ch_end),
  .dev_end   (dev_end)
);

// File: tb/rd_handoff_buf_tb_top.sv
`timescale 1ns/1ps
module rd_handoff_buf_tb_top;
  localparam int DEPTH = 2048;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [7:0] RD = 8'h02;

  logic clk = 0, rst_n = 0;
  logic sel_start = 0, fill_valid = 0, cmd_valid = 0, cmd_chain = 0, cmd_sli = 0;
  logic unit_check = 0, out_ready = 1;
  logic [CW-1:0] sel_count = '0, cmd_count = '0;
  logic [7:0] fill_data = 0, cmd_opcode = 0;
  logic fill_ready, out_valid, ch_end, dev_end, bad_len;
  logic [7:0] out_data;

  int checks = 0, fails = 0;
  bit bp_on = 0, done = 0;
  int bp_cnt = 0;
  logic [7:0] exp_q[$];
  string cur_req = "R3";

  always #2 clk = ~clk;

  rd_handoff_buf #(.DEPTH(DEPTH), .READ_OP(RD)) dut_i (.*);

  function automatic logic [7:0] pat(int seed, int i);
    return 8'((seed * 37) + (i * 13) + (i >> 8));
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // out_ready pattern, changed just after each rising edge
  always @(posedge clk) begin
    #1;
    bp_cnt++;
    out_ready = bp_on ? ((bp_cnt % 3) != 0 && (bp_cnt % 7) != 2) : 1'b1;
  end

  // monitor: scoreboard compare and stall-hold check
  logic prev_stall = 0;
  logic [7:0] prev_data = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        chk("R9", {out_valid, out_data}, {1'b1, prev_data});
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) chk(cur_req, 1, 0);
        else chk(cur_req, out_data, exp_q.pop_front());
      end
      prev_stall = out_valid && !out_ready && !unit_check;
      prev_data  = out_data;
    end
  end

  task automatic do_select(int n, int seed);
    int i = 0;
    @(negedge clk);
    sel_start = 1; sel_count = CW'(n);
    @(negedge clk);
    sel_start = 0;
    chk("R1", {ch_end, dev_end}, 2'b10);
    while (i < n) begin
      fill_valid = 1; fill_data = pat(seed, i);
      if (fill_ready) i++;
      @(negedge clk);
    end
    fill_valid = 0;
    if (n == 0) @(negedge clk);
    chk("R2", {dev_end, ch_end, fill_ready}, 3'b100);
  endtask

  task automatic do_read(logic [7:0] op, bit chain, int cnt, bit sli,
                         int seed, int exp_n, bit exp_bad, string req);
    int g = 0;
    cur_req = req;
    for (int i = 0; i < exp_n; i++) exp_q.push_back(pat(seed, i));
    @(negedge clk);
    cmd_valid = 1; cmd_opcode = op; cmd_chain = chain;
    cmd_count = CW'(cnt); cmd_sli = sli;
    @(negedge clk);
    cmd_valid = 0;
    while (!ch_end && g < 20000) begin @(negedge clk); g++; end
    chk({req, " ce"}, ch_end, 1);
    chk({req, " remaining"}, exp_q.size(), 0);
    chk("R4", bad_len, exp_bad);
    chk("R10", dev_end, 0);
    @(negedge clk);
    chk("R5", {dev_end, ch_end}, 2'b10);
    exp_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("reset", {out_valid, fill_ready, ch_end, dev_end, bad_len}, 5'b0);

    // equal counts
    do_select(10, 1);
    do_read(RD, 1, 10, 0, 1, 10, 0, "R3");

    // shorter read, then second read gets nothing
    do_select(12, 2);
    do_read(RD, 1, 5, 0, 2, 5, 1, "R3");
    do_read(RD, 1, 5, 0, 2, 0, 1, "R6");

    // longer read with suppression
    do_select(6, 3);
    do_read(RD, 1, 9, 1, 3, 6, 0, "R3");

    // unchained command discards
    do_select(7, 4);
    @(negedge clk);
    cmd_valid = 1; cmd_opcode = RD; cmd_chain = 0; cmd_count = CW'(7);
    @(negedge clk);
    cmd_valid = 0;
    repeat (2) begin
      chk("R7", {out_valid, ch_end, dev_end}, 3'b0);
      @(negedge clk);
    end
    do_read(RD, 1, 7, 0, 4, 0, 1, "R7");

    // other opcode discards
    do_select(4, 5);
    @(negedge clk);
    cmd_valid = 1; cmd_opcode = 8'h11; cmd_chain = 1; cmd_count = CW'(4);
    @(negedge clk);
    cmd_valid = 0;
    chk("R7", {out_valid, ch_end, dev_end}, 3'b0);
    do_read(RD, 1, 0, 0, 5, 0, 0, "R7");

    // zero-length select
    do_select(0, 6);
    do_read(RD, 1, 3, 1, 6, 0, 0, "R6");

    // unit check mid-fill
    @(negedge clk);
    sel_start = 1; sel_count = CW'(8);
    @(negedge clk);
    sel_start = 0;
    for (int i = 0; i < 4; i++) begin
      fill_valid = 1; fill_data = pat(7, i);
      @(negedge clk);
    end
    fill_valid = 0; unit_check = 1;
    @(negedge clk);
    unit_check = 0;
    chk("R8", {out_valid, fill_ready, ch_end, dev_end, bad_len}, 5'b0);
    do_read(RD, 1, 8, 0, 7, 0, 1, "R8");

    // full depth with back-pressure
    do_select(DEPTH, 8);
    bp_on = 1;
    do_read(RD, 1, DEPTH, 0, 8, DEPTH, 0, "R9");
    bp_on = 0;

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule